// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a countdown watchdog that runs from its own slow counter clock and is managed through a small register window on the bus clock. Software starts the watchdog with a start key. It then has to write a refresh key often enough to stop the counter from reaching zero. If the counter does reach zero, the block raises a reset request for one counter-clock cycle, reloads itself and counts again. Once started, the watchdog keeps running until the next reset.

The divide ratio and the reload value can only be written after an unlock key has been written. Each accepted write is staged in the bus domain and handed to the counter domain over a toggle handshake with two-flop synchronizers. While a handover is in progress, a busy flag stays set and further writes to that field are dropped. Reads of the divide ratio and the reload value return the copy held in the counter domain. A read is only meaningful once the matching busy flag has cleared.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the divider field reads 0, the reload field reads 0xFFF, the status word reads 0 and `rst_req` is low.
- R2: Writing key 0x5555 unlocks the divider and reload fields. Writing any other key value locks them again. A write to either field while it is locked has no effect on the value read back.
- R3: An accepted write sets a busy flag in the status word: bit 0 for the divider and bit 1 for the reload. The flag clears after a synchronizer round trip. A write to a field while its busy flag is set is dropped.
- R4: Divider and reload reads return the counter-domain copy, so they show the old value while the busy flag is set and the new value once it clears. Only the low 3 bits of the divider and the low 12 bits of the reload are stored. All other bits read as zero.
- R5: Divider code c gives a divide ratio of 4·2^c for c from 0 to 6. Code 7 divides by 256, the same as code 6.
- R6: Key 0xCCCC starts the watchdog. Before the start, `rst_req` never rises. After the start, no key value stops the watchdog.
- R7: While the watchdog is running and not refreshed, `rst_req` is high for exactly one counter-clock cycle. Successive pulses are (reload+1)·divide counter-clock cycles apart.
- R8: Key 0xAAAA reloads the counter from the reload value and restarts the divider. Refreshing more often than the timeout keeps `rst_req` low.
- R9: The register map is: address 0 is the key, 1 is the divider, 2 is the reload and 3 is the status word. The key address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset, bus domain |
| wclk | input | 1 | Counter clock |
| wrst_n | input | 1 | Synchronous active-low reset, counter domain |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational on `addr` |
| rst_req | output | 1 | One counter-clock reset request on expiry |

## Verification
The embedded assertions check on every cycle the properties that hold locally:
- locked writes and writes made while busy leave the staged value and the request toggle untouched;
- an accepted write raises its busy flag;
- the started and running states never fall;
- no request is raised before the start;
- a request never lasts more than one counter cycle.

Other behaviour can only be shown by the directed scenarios, because it needs elapsed time across both clocks:
- the divide ratio for each code;
- the spacing of requests set by reload and divider together;
- the old-value readback during a handover;
- refreshes holding off expiry.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, key values, register addresses and the divider decode.
// Assumes the divider code saturates at the highest distinct ratio.
package kwdt_pkg;
    localparam int KEY_W        = 16;
    localparam int PR_W         = 3;
    localparam int RL_W         = 12;
    localparam int DIV_LOG2_MIN = 2;
    localparam int PR_TOP       = (1 << PR_W) - 2;
    localparam int PSC_W        = DIV_LOG2_MIN + PR_TOP;

    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [RL_W-1:0]  RL_RESET    = '1;

    typedef enum logic [1:0] {
        A_KEY  = 2'd0,
        A_PRE  = 2'd1,
        A_RLD  = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    // Last prescaler count value (divide ratio minus one) for a code.
    function automatic logic [PSC_W-1:0] div_last(input logic [PR_W-1:0] code);
        int sh;
        sh = (int'(code) > PR_TOP) ? PR_TOP : int'(code);
        return PSC_W'((1 << (DIV_LOG2_MIN + sh)) - 1);
    endfunction
endpackage

// File: rtl/kwdt_sync.sv
`timescale 1ns/1ps
// Module: multi-stage flop synchronizer, one independent chain per bit.
// Assumes each bit is a level or toggle that is stable for several destination cycles.
module kwdt_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous input through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/kwdt_bus_regs.sv
`timescale 1ns/1ps
// Module: bus-side register window. Decodes keys, guards configuration
// writes with the unlock state and busy flags, stages values and raises
// request toggles toward the counter domain.
// Assumes staged values stay stable while their busy flag is set.
module kwdt_bus_regs
    import kwdt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [KEY_W-1:0] wdata,
    output logic [KEY_W-1:0] rdata,
    input  logic [PR_W-1:0]  pr_cfg,
    input  logic [RL_W-1:0]  rl_cfg,
    input  logic             pr_ack_tog,
    input  logic             rl_ack_tog,
    output logic [PR_W-1:0]  pr_stage,
    output logic [RL_W-1:0]  rl_stage,
    output logic             pr_req_tog,
    output logic             rl_req_tog,
    output logic             ref_tog,
    output logic             start_lvl
);
    logic       unlocked;
    logic [1:0] ack_s;
    logic       pr_busy;
    logic       rl_busy;

    kwdt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rl_ack_tog, pr_ack_tog}),
        .q     (ack_s)
    );

    assign pr_busy = pr_req_tog ^ ack_s[0];
    assign rl_busy = rl_req_tog ^ ack_s[1];

    // Key decode, guarded staging of configuration and request toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked   <= 1'b0;
            start_lvl  <= 1'b0;
            ref_tog    <= 1'b0;
            pr_stage   <= '0;
            rl_stage   <= RL_RESET;
            pr_req_tog <= 1'b0;
            rl_req_tog <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                A_KEY: begin
                    unlocked <= (wdata == KEY_UNLOCK);
                    if (wdata == KEY_REFRESH) ref_tog <= ~ref_tog;
                    if (wdata == KEY_START) start_lvl <= 1'b1;
                end
                A_PRE: begin
                    if (unlocked && !pr_busy) begin
                        pr_stage   <= wdata[PR_W-1:0];
                        pr_req_tog <= ~pr_req_tog;
                    end
                end
                A_RLD: begin
                    if (unlocked && !rl_busy) begin
                        rl_stage   <= wdata[RL_W-1:0];
                        rl_req_tog <= ~rl_req_tog;
                    end
                end
                default: ;
            endcase
        end
    end

    // Read multiplexer: configuration is read from the counter-domain copy.
    always_comb begin
        case (reg_addr_e'(addr))
            A_PRE:   rdata = {{(KEY_W-PR_W){1'b0}}, pr_cfg};
            A_RLD:   rdata = {{(KEY_W-RL_W){1'b0}}, rl_cfg};
            A_STAT:  rdata = {{(KEY_W-2){1'b0}}, rl_busy, pr_busy};
            default: rdata = '0;
        endcase
    end

    assert_locked_pr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PRE && !unlocked) |=> ($stable(pr_stage) && $stable(pr_req_tog)));
    assert_locked_rl_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_RLD && !unlocked) |=> ($stable(rl_stage) && $stable(rl_req_tog)));
    assert_busy_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PRE && pr_busy) |=> $stable(pr_stage));
    assert_accept_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_RLD && unlocked && !rl_busy) |=> rl_busy);
    assert_start_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_lvl |=> start_lvl);
endmodule

// File: rtl/kwdt_counter.sv
`timescale 1ns/1ps
// Module: counter-domain logic. Captures handed-over configuration, runs
// the prescaler and the down counter, and pulses the reset request on expiry.
// Assumes the bus side holds the staged values stable until acknowledged.
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            wclk,
    input  logic            wrst_n,
    input  logic [PR_W-1:0] pr_stage,
    input  logic [RL_W-1:0] rl_stage,
    input  logic            pr_req_tog,
    input  logic            rl_req_tog,
    input  logic            ref_tog,
    input  logic            start_lvl,
    output logic [PR_W-1:0] pr_cfg,
    output logic [RL_W-1:0] rl_cfg,
    output logic            pr_ack_tog,
    output logic            rl_ack_tog,
    output logic            rst_req
);
    logic [3:0]       in_s;
    logic             pr_req_s, rl_req_s, ref_s, start_s;
    logic             ref_seen;
    logic             run;
    logic             load;
    logic [PSC_W-1:0] psc;
    logic [RL_W-1:0]  cnt;

    kwdt_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_in_sync (
        .clk   (wclk),
        .rst_n (wrst_n),
        .d     ({start_lvl, ref_tog, rl_req_tog, pr_req_tog}),
        .q     (in_s)
    );
    assign {start_s, ref_s, rl_req_s, pr_req_s} = in_s;

    assign load = (ref_s != ref_seen) || (start_s && !run);

    // Capture handed-over configuration and acknowledge it by echoing the toggle.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            pr_cfg     <= '0;
            rl_cfg     <= RL_RESET;
            pr_ack_tog <= 1'b0;
            rl_ack_tog <= 1'b0;
        end else begin
            if (pr_req_s != pr_ack_tog) begin
                pr_cfg     <= pr_stage;
                pr_ack_tog <= pr_req_s;
            end
            if (rl_req_s != rl_ack_tog) begin
                rl_cfg     <= rl_stage;
                rl_ack_tog <= rl_req_s;
            end
        end
    end

    // Prescaler, down counter, start latch and expiry pulse.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            run      <= 1'b0;
            ref_seen <= 1'b0;
            psc      <= '0;
            cnt      <= RL_RESET;
            rst_req  <= 1'b0;
        end else begin
            rst_req  <= 1'b0;
            ref_seen <= ref_s;
            if (start_s) run <= 1'b1;
            if (load) begin
                cnt <= rl_cfg;
                psc <= '0;
            end else if (run) begin
                if (psc >= div_last(pr_cfg)) begin
                    psc <= '0;
                    if (cnt == '0) begin
                        rst_req <= 1'b1;
                        cnt     <= rl_cfg;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end else begin
                    psc <= psc + 1'b1;
                end
            end
        end
    end

    assert_run_sticky_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
        run |=> run);
    assert_idle_no_request_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
        !run |-> !rst_req);
    assert_request_one_cycle_R7: assert property (@(posedge wclk) disable iff (!wrst_n)
        rst_req |=> !rst_req);
    assert_load_restarts_prescaler_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
        load |=> (psc == '0 && !rst_req));
endmodule

// File: rtl/kwdt_top.sv
`timescale 1ns/1ps
// Module: top of the key-protected watchdog. Joins the bus register window
// and the counter domain; the two clocks are treated as unrelated.
// Assumes each reset is held for at least the synchronizer depth in its domain.
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wclk,
    input  logic             wrst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [KEY_W-1:0] wdata,
    output logic [KEY_W-1:0] rdata,
    output logic             rst_req
);
    logic [PR_W-1:0] pr_cfg, pr_stage;
    logic [RL_W-1:0] rl_cfg, rl_stage;
    logic            pr_ack_tog, rl_ack_tog;
    logic            pr_req_tog, rl_req_tog;
    logic            ref_tog, start_lvl;

    kwdt_bus_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .pr_cfg     (pr_cfg),
        .rl_cfg     (rl_cfg),
        .pr_ack_tog (pr_ack_tog),
        .rl_ack_tog (rl_ack_tog),
        .pr_stage   (pr_stage),
        .rl_stage   (rl_stage),
        .pr_req_tog (pr_req_tog),
        .rl_req_tog (rl_req_tog),
        .ref_tog    (ref_tog),
        .start_lvl  (start_lvl)
    );

    kwdt_counter #(.SYNC_STAGES(SYNC_STAGES)) u_counter (
        .wclk       (wclk),
        .wrst_n     (wrst_n),
        .pr_stage   (pr_stage),
        .rl_stage   (rl_stage),
        .pr_req_tog (pr_req_tog),
        .rl_req_tog (rl_req_tog),
        .ref_tog    (ref_tog),
        .start_lvl  (start_lvl),
        .pr_cfg     (pr_cfg),
        .rl_cfg     (rl_cfg),
        .pr_ack_tog (pr_ack_tog),
        .rl_ack_tog (rl_ack_tog),
        .rst_req    (rst_req)
    );
endmodule

// File: tb/kwdt_top_tb.sv
`timescale 1ns/1ps
// Directed bench for kwdt_top: one task per scenario, each checking its results.
module kwdt_top_tb;
    logic        clk = 1'b0;
    logic        wclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wrst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int pulse_cnt = 0;
    int run_len = 0;
    int max_run = 0;
    bit done = 0;

    always #10 clk = ~clk;
    always #35 wclk = ~wclk;

    kwdt_top u_dut (
        .clk(clk), .rst_n(rst_n), .wclk(wclk), .wrst_n(wrst_n),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
    );

    // Pulse monitor sampled away from the counter-clock active edge.
    always @(negedge wclk) begin
        if (rst_req) begin
            pulse_cnt++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic wait_idle(input string tag);
        int v = -1;
        for (int i = 0; i < 400; i++) begin
            rd(2'd3, v);
            if (v == 0) return;
        end
        chk(1'b0, tag, v, 0);
    endtask

    task automatic measure(output int per);
        int g = 0;
        @(negedge wclk);
        while (!rst_req && g < 100000) begin
            @(negedge wclk);
            g++;
        end
        per = 0;
        do begin
            @(negedge wclk);
            per++;
        end while (!rst_req && per < 100000);
    endtask

    function automatic int exp_div(input int c);
        case (c)
            0: return 4;
            1: return 8;
            2: return 16;
            3: return 32;
            4: return 64;
            5: return 128;
            default: return 256;
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; wrst_n = 1'b0;
        repeat (8) @(negedge wclk);
        rst_n = 1'b1; wrst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        rd(2'd1, v); chk(v == 0, "R1 divider reset", v, 0);
        rd(2'd2, v); chk(v == 'hFFF, "R1 reload reset", v, 'hFFF);
        rd(2'd3, v); chk(v == 0, "R1 status reset", v, 0);
        chk(rst_req == 1'b0, "R1 rst_req low", int'(rst_req), 0);
        rd(2'd0, v); chk(v == 0, "R9 key reads zero", v, 0);
    endtask

    task automatic t_lock();
        int v;
        wr(2'd1, 16'd5);
        repeat (60) @(negedge clk);
        rd(2'd1, v); chk(v == 0, "R2 locked divider write ignored", v, 0);
        rd(2'd3, v); chk(v == 0, "R2 locked write sets no busy", v, 0);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'h0010);
        repeat (60) @(negedge clk);
        rd(2'd2, v); chk(v == 'hFFF, "R2 relocked reload write ignored", v, 'hFFF);
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'h0010);
        wait_idle("R2 idle after unlock write");
        rd(2'd2, v); chk(v == 'h10, "R2 unlocked reload write", v, 'h10);
    endtask

    task automatic t_busy();
        int v;
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'hFFFD);
        rd(2'd3, v); chk(v == 1, "R3 divider busy set", v, 1);
        rd(2'd1, v); chk(v == 0, "R4 old divider while busy", v, 0);
        wr(2'd1, 16'd2);
        wait_idle("R3 divider busy clears");
        rd(2'd1, v); chk(v == 5, "R3 R4 busy write dropped, upper bits masked", v, 5);
        wr(2'd2, 16'hF123);
        rd(2'd3, v); chk(v == 2, "R3 reload busy set", v, 2);
        rd(2'd2, v); chk(v == 'h10, "R4 old reload while busy", v, 'h10);
        wait_idle("R3 reload busy clears");
        rd(2'd2, v); chk(v == 'h123, "R4 reload masked to 12 bits", v, 'h123);
    endtask

    task automatic t_start();
        int per, base;
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd3);
        wait_idle("R6 idle before start");
        base = pulse_cnt;
        repeat (300) @(negedge clk);
        chk(pulse_cnt == base, "R6 no request before start", pulse_cnt - base, 0);
        wr(2'd0, 16'hCCCC);
        measure(per);
        chk(per == 16, "R7 period reload 3 div 4", per, 16);
        chk(max_run == 1, "R7 one-cycle pulse", max_run, 1);
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd9);
        wait_idle("R7 idle after reload change");
        measure(per);
        chk(per == 40, "R7 period reload 9 div 4", per, 40);
    endtask

    task automatic t_encoding();
        int per;
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd1);
        wait_idle("R5 idle after reload");
        for (int c = 1; c < 8; c++) begin
            wr(2'd0, 16'h5555);
            wr(2'd1, 16'(c));
            wait_idle("R5 idle after divider");
            measure(per);
            chk(per == 2 * exp_div(c), $sformatf("R5 divider code %0d", c), per, 2 * exp_div(c));
        end
    endtask

    task automatic t_refresh();
        int per, base;
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd15);
        wait_idle("R8 idle after config");
        wr(2'd0, 16'hAAAA);
        repeat (20) @(negedge clk);
        base = pulse_cnt;
        for (int i = 0; i < 30; i++) begin
            wr(2'd0, 16'hAAAA);
            repeat (90) @(negedge clk);
        end
        chk(pulse_cnt == base, "R8 refresh holds off request", pulse_cnt - base, 0);
        wr(2'd0, 16'h0000);
        measure(per);
        chk(per == 64, "R6 R8 other key cannot stop, period 64", per, 64);
        chk(max_run == 1, "R7 pulse width stays one cycle", max_run, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_lock();
        t_busy();
        t_start();
        t_encoding();
        t_refresh();
        done = 1;
        summary();
        $finish;
    end
endmodule